// File: doc/BRIEF.md
# JTAG Padded Register Scan Sequencer

This block runs one complete instruction-register or data-register scan on a JTAG daisy chain, one TCK step per clock cycle. On a start request it takes the scan type, the stable state the TAP is in now, and a stop state. It also takes three bit fields: pad bits for the devices ahead of the addressed one, the target bits, and pad bits for the devices behind it. Either pad field can be replaced by all ones. The block produces the TMS/TDI stream for the whole scan. It captures TDO while the target bits pass through and returns those bits aligned to bit 0, discarding the pad positions.

The TAP is always left in the pause state of the scanned register. If the requested stop state is a different state, the block hands that move to an external navigator through a request/acknowledge pair. The same pair is used before the scan when the TAP is not in one of the three states a scan may start from. An adapter outside the block turns each `bit_vld` cycle into one TCK pulse and presents the TDO of that pulse on `tdo` in the same cycle.

Top module: `jscan_engine`

## Requirements
- R1: TAP states are carried as 4-bit codes. 0 is run-test/idle and 1 is test-logic-reset. The data-register states are 2 select, 3 capture, 4 shift, 5 exit1, 6 pause, 7 exit2 and 8 update. The instruction-register states use the same order on codes 9 to 15: 9 select, 10 capture, 11 shift, 12 exit1, 13 pause, 14 exit2 and 15 update.
- R2: `start` is accepted only while `busy` is low. A request made while a scan is running has no effect on the stream. `done` is a single-cycle pulse, and `busy` is low in the cycle after it.
- R3: When the scan starts from idle, the entry steps carry TDI 0. A data scan uses TMS 1,0,0 to enter shift. An instruction scan uses TMS 1,1,0,0.
- R4: When the scan starts from code 6 or code 13, two TMS 1 steps come first, passing through exit2 and update. The idle-start sequence of R3 follows.
- R5: When the scan starts from any other code, `nav_req` is raised with `nav_state` = 0. It is held until `nav_done`, and the R3 sequence follows.
- R6: The shift loop sends pre_len + tgt_len + post_len bits. The preamble goes first, then the target, then the postamble, each field starting at its bit 0. TMS is 0 on every shift bit except the last one, which carries TMS 1.
- R7: When `pre_ones` or `post_ones` is set, every bit of that pad field is shifted as 1, whatever the supplied vector holds.
- R8: After the last shift bit, exactly one step with TMS 0 and TDI 0 is sent, which leaves the TAP in pause (code 6 or 13). If the total length is zero, the step into shift is replaced by TMS 1 (capture to exit1), and that pause step follows.
- R9: If `stop_state` differs from the pause code of the scanned register, `nav_req` is raised with `nav_state` = `stop_state` until `nav_done`, and `done` follows. Otherwise `done` follows the pause step without any navigation request.
- R10: With `cap_en` set, TDO of target bit k lands in `cap_data[k]`. Positions at or above `tgt_len` read 0, and pad-bit TDO values are discarded.
- R11: With `cap_en` clear, `cap_data` keeps the value it had before the scan.
- R12: Each `bit_vld` cycle is one TCK step, and `nav_req` is never high in the same cycle as `bit_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one TCK step per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Scan request, taken when not busy |
| scan_ir | input | 1 | 1 = instruction-register scan, 0 = data-register scan |
| cur_state | input | 4 | Current TAP state code |
| stop_state | input | 4 | TAP state code to finish in |
| pre_len | input | 5 | Preamble bit count (0..MAX_PAD) |
| tgt_len | input | 6 | Target bit count (0..MAX_TGT) |
| post_len | input | 5 | Postamble bit count (0..MAX_PAD) |
| pre_bits | input | 16 | Preamble values, bit 0 first |
| tgt_bits | input | 32 | Target values, bit 0 first |
| post_bits | input | 16 | Postamble values, bit 0 first |
| pre_ones | input | 1 | Shift the preamble as all ones |
| post_ones | input | 1 | Shift the postamble as all ones |
| cap_en | input | 1 | Store target TDO into cap_data |
| tdo | input | 1 | TDO of the current TCK step |
| nav_done | input | 1 | Navigator finished the requested move |
| tms | output | 1 | TMS for the current step |
| tdi | output | 1 | TDI for the current step |
| bit_vld | output | 1 | A TCK step is issued this cycle |
| nav_req | output | 1 | Navigation request |
| nav_state | output | 4 | Target state code of the navigation |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | One-cycle completion pulse |
| cap_data | output | 32 | Captured target bits |

## Verification
Two pairs of functions can fall in the same cycle, and both are exercised directly.

The first pair is a new `start` arriving while the shift loop is running. The bench provokes it by pulsing `start` mid-scan with a different scan type and length. It judges the result by whether the scoreboard's expected TMS/TDI queue drains exactly, with no extra step.

The second pair is the final shift bit, which carries both the TMS 1 exit and a target capture when there is no postamble. This is judged from `cap_data`, from the bench's own TAP model ending in the pause code, and from the following step being TMS 0.

// File: rtl/jscan_pkg.sv
package jscan_pkg;

  localparam logic [3:0] TAP_IDLE   = 4'd0;
  localparam logic [3:0] TAP_RESET  = 4'd1;
  localparam logic [3:0] TAP_DR_PAU = 4'd6;
  localparam logic [3:0] TAP_IR_PAU = 4'd13;

  localparam int STEP_W = 3;

  typedef enum logic [2:0] {
    SQ_WAIT,
    SQ_NAV_IN,
    SQ_ENTRY,
    SQ_SHIFT,
    SQ_PAUSE,
    SQ_NAV_OUT,
    SQ_FIN
  } seq_e;

  function automatic logic scan_start_ok(input logic [3:0] s);
    return (s == TAP_IDLE) || (s == TAP_DR_PAU) || (s == TAP_IR_PAU);
  endfunction

endpackage

// File: rtl/jscan_entry.sv
module jscan_entry
  import jscan_pkg::*;
#(
  parameter int PREFIX_LEN = 2
) (
  input  logic              from_pause,
  input  logic              scan_ir,
  input  logic              zero_len,
  input  logic [STEP_W-1:0] step,
  output logic              tms,
  output logic              last
);

  // body: select steps, capture step, step into shift (or exit1)
  localparam int DR_BODY = 3;
  localparam int IR_BODY = 4;

  logic [STEP_W-1:0] pre_n;
  logic [STEP_W-1:0] body_n;
  logic [STEP_W-1:0] sel_n;
  logic [STEP_W-1:0] rel;

  always_comb begin
    pre_n  = from_pause ? STEP_W'(PREFIX_LEN) : '0;
    body_n = scan_ir ? STEP_W'(IR_BODY) : STEP_W'(DR_BODY);
    sel_n  = scan_ir ? STEP_W'(2) : STEP_W'(1);
    rel    = step - pre_n;
    tms    = 1'b0;
    last   = 1'b0;
    if (step < pre_n) begin
      tms = 1'b1;
    end else if (rel < sel_n) begin
      tms = 1'b1;
    end else if (rel == body_n - STEP_W'(1)) begin
      tms  = zero_len;
      last = 1'b1;
    end else begin
      tms = 1'b0;
    end
  end

endmodule

// File: rtl/jscan_shifter.sv
module jscan_shifter #(
  parameter int MAX_PAD = 16,
  parameter int MAX_TGT = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               load,
  input  logic                               shift_en,
  input  logic [$clog2(MAX_PAD+1)-1:0]       pre_len,
  input  logic [$clog2(MAX_TGT+1)-1:0]       tgt_len,
  input  logic [$clog2(MAX_PAD+1)-1:0]       post_len,
  input  logic [MAX_PAD-1:0]                 pre_bits,
  input  logic [MAX_TGT-1:0]                 tgt_bits,
  input  logic [MAX_PAD-1:0]                 post_bits,
  input  logic                               pre_ones,
  input  logic                               post_ones,
  input  logic                               cap_en,
  input  logic                               tdo,
  output logic                               tdi,
  output logic                               last,
  output logic                               zero_len,
  output logic [MAX_TGT-1:0]                 cap_data
);

  localparam int PLW = $clog2(MAX_PAD + 1);
  localparam int TLW = $clog2(MAX_TGT + 1);
  localparam int IW  = $clog2(2 * MAX_PAD + MAX_TGT + 1);

  logic [PLW-1:0]     pre_l_q, post_l_q;
  logic [TLW-1:0]     tgt_l_q;
  logic [MAX_PAD-1:0] pre_sr_q, post_sr_q, pre_sr_d, post_sr_d;
  logic [MAX_TGT-1:0] tgt_sr_q, tgt_sr_d;
  logic [IW-1:0]      idx_q, idx_d;
  logic               cen_q;
  logic [MAX_TGT-1:0] cap_q, cap_d;
  logic [MAX_TGT-1:0] cap_we;

  logic [IW-1:0] total;
  logic [IW-1:0] tgt_end;
  logic          in_pre, in_tgt;

  assign total    = IW'(pre_l_q) + IW'(tgt_l_q) + IW'(post_l_q);
  assign tgt_end  = IW'(pre_l_q) + IW'(tgt_l_q);
  assign in_pre   = idx_q < IW'(pre_l_q);
  assign in_tgt   = !in_pre && (idx_q < tgt_end);
  assign zero_len = (total == '0);
  assign last     = (idx_q == total - IW'(1));
  assign tdi      = in_pre ? pre_sr_q[0] : (in_tgt ? tgt_sr_q[0] : post_sr_q[0]);
  assign cap_data = cap_q;

  // next-state of the field shift registers and bit index
  always_comb begin
    pre_sr_d  = pre_sr_q;
    tgt_sr_d  = tgt_sr_q;
    post_sr_d = post_sr_q;
    idx_d     = idx_q;
    if (load) begin
      pre_sr_d  = pre_ones  ? '1 : pre_bits;
      post_sr_d = post_ones ? '1 : post_bits;
      tgt_sr_d  = tgt_bits;
      idx_d     = '0;
    end else if (shift_en) begin
      idx_d = idx_q + IW'(1);
      if (in_pre)      pre_sr_d  = {1'b0, pre_sr_q[MAX_PAD-1:1]};
      else if (in_tgt) tgt_sr_d  = {1'b0, tgt_sr_q[MAX_TGT-1:1]};
      else             post_sr_d = {1'b0, post_sr_q[MAX_PAD-1:1]};
    end
  end

  // one write port per capture bit
  for (genvar k = 0; k < MAX_TGT; k++) begin : g_cap
    assign cap_we[k] = shift_en && cen_q && in_tgt && (idx_q == IW'(pre_l_q) + IW'(k));
    assign cap_d[k]  = cap_we[k] ? tdo : ((load && cap_en) ? 1'b0 : cap_q[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_l_q   <= '0;
      tgt_l_q   <= '0;
      post_l_q  <= '0;
      cen_q     <= 1'b0;
    end else if (load) begin
      pre_l_q   <= pre_len;
      tgt_l_q   <= tgt_len;
      post_l_q  <= post_len;
      cen_q     <= cap_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_sr_q  <= '0;
      tgt_sr_q  <= '0;
      post_sr_q <= '0;
      idx_q     <= '0;
      cap_q     <= '0;
    end else begin
      pre_sr_q  <= pre_sr_d;
      tgt_sr_q  <= tgt_sr_d;
      post_sr_q <= post_sr_d;
      idx_q     <= idx_d;
      cap_q     <= cap_d;
    end
  end

  // R6
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> (idx_q < total));

  // R11
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !cen_q) |=> $stable(cap_q));

endmodule

// File: rtl/jscan_ctrl.sv
module jscan_ctrl
  import jscan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              scan_ir,
  input  logic [3:0]        cur_state,
  input  logic [3:0]        stop_state,
  input  logic              nav_done,
  input  logic              ent_tms,
  input  logic              ent_last,
  input  logic              shf_last,
  input  logic              shf_tdi,
  input  logic              zero_len,
  output logic [STEP_W-1:0] ent_step,
  output logic              from_pause,
  output logic              ir_sel,
  output logic              load,
  output logic              shift_en,
  output logic              bit_vld,
  output logic              tms,
  output logic              tdi,
  output logic              nav_req,
  output logic [3:0]        nav_state,
  output logic              busy,
  output logic              done
);

  seq_e              st_q, st_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              ir_q, fp_q, fp_d;
  logic [3:0]        stop_q;
  logic              accept, start_ok;
  logic [3:0]        pause_code;

  assign accept     = (st_q == SQ_WAIT) && start;
  assign start_ok   = scan_start_ok(cur_state);
  assign pause_code = ir_q ? TAP_IR_PAU : TAP_DR_PAU;
  assign fp_d       = start_ok && (cur_state != TAP_IDLE);

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    unique case (st_q)
      SQ_WAIT: begin
        step_d = '0;
        if (start) st_d = start_ok ? SQ_ENTRY : SQ_NAV_IN;
      end
      SQ_NAV_IN: begin
        if (nav_done) st_d = SQ_ENTRY;
      end
      SQ_ENTRY: begin
        if (ent_last) begin
          step_d = '0;
          st_d   = zero_len ? SQ_PAUSE : SQ_SHIFT;
        end else begin
          step_d = step_q + STEP_W'(1);
        end
      end
      SQ_SHIFT: begin
        if (shf_last) st_d = SQ_PAUSE;
      end
      SQ_PAUSE: begin
        st_d = (stop_q == pause_code) ? SQ_FIN : SQ_NAV_OUT;
      end
      SQ_NAV_OUT: begin
        if (nav_done) st_d = SQ_FIN;
      end
      SQ_FIN: st_d = SQ_WAIT;
      default: st_d = SQ_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_WAIT;
      step_q <= '0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q   <= 1'b0;
      fp_q   <= 1'b0;
      stop_q <= TAP_IDLE;
    end else if (accept) begin
      ir_q   <= scan_ir;
      fp_q   <= fp_d;
      stop_q <= stop_state;
    end
  end

  always_comb begin
    bit_vld = 1'b0;
    tms     = 1'b0;
    tdi     = 1'b0;
    unique case (st_q)
      SQ_ENTRY: begin bit_vld = 1'b1; tms = ent_tms; end
      SQ_SHIFT: begin bit_vld = 1'b1; tms = shf_last; tdi = shf_tdi; end
      SQ_PAUSE: begin bit_vld = 1'b1; end
      default:  begin bit_vld = 1'b0; end
    endcase
  end

  assign ent_step   = step_q;
  assign from_pause = fp_q;
  assign ir_sel     = ir_q;
  assign load       = accept;
  assign shift_en   = (st_q == SQ_SHIFT);
  assign nav_req    = (st_q == SQ_NAV_IN) || (st_q == SQ_NAV_OUT);
  assign nav_state  = (st_q == SQ_NAV_IN) ? TAP_IDLE : stop_q;
  assign busy       = (st_q != SQ_WAIT);
  assign done       = (st_q == SQ_FIN);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R9
  nav_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nav_req && !nav_done) |=> (nav_req && $stable(nav_state)));

  // R8
  pause_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && shf_last) |=> (bit_vld && !tms && !tdi && !shift_en));

  // R5
  nav_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !start_ok) |=> (nav_req && nav_state == TAP_IDLE && !bit_vld));

endmodule

// File: rtl/jscan_engine.sv
module jscan_engine
  import jscan_pkg::*;
#(
  parameter int MAX_PAD = 16,
  parameter int MAX_TGT = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         scan_ir,
  input  logic [3:0]                   cur_state,
  input  logic [3:0]                   stop_state,
  input  logic [$clog2(MAX_PAD+1)-1:0] pre_len,
  input  logic [$clog2(MAX_TGT+1)-1:0] tgt_len,
  input  logic [$clog2(MAX_PAD+1)-1:0] post_len,
  input  logic [MAX_PAD-1:0]           pre_bits,
  input  logic [MAX_TGT-1:0]           tgt_bits,
  input  logic [MAX_PAD-1:0]           post_bits,
  input  logic                         pre_ones,
  input  logic                         post_ones,
  input  logic                         cap_en,
  input  logic                         tdo,
  input  logic                         nav_done,
  output logic                         tms,
  output logic                         tdi,
  output logic                         bit_vld,
  output logic                         nav_req,
  output logic [3:0]                   nav_state,
  output logic                         busy,
  output logic                         done,
  output logic [MAX_TGT-1:0]           cap_data
);

  logic [STEP_W-1:0] ent_step;
  logic ent_tms, ent_last, from_pause, ir_sel;
  logic load, shift_en, shf_last, shf_tdi, zero_len;

  jscan_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .scan_ir    (scan_ir),
    .cur_state  (cur_state),
    .stop_state (stop_state),
    .nav_done   (nav_done),
    .ent_tms    (ent_tms),
    .ent_last   (ent_last),
    .shf_last   (shf_last),
    .shf_tdi    (shf_tdi),
    .zero_len   (zero_len),
    .ent_step   (ent_step),
    .from_pause (from_pause),
    .ir_sel     (ir_sel),
    .load       (load),
    .shift_en   (shift_en),
    .bit_vld    (bit_vld),
    .tms        (tms),
    .tdi        (tdi),
    .nav_req    (nav_req),
    .nav_state  (nav_state),
    .busy       (busy),
    .done       (done)
  );

  jscan_entry #(.PREFIX_LEN(2)) u_entry (
    .from_pause (from_pause),
    .scan_ir    (ir_sel),
    .zero_len   (zero_len),
    .step       (ent_step),
    .tms        (ent_tms),
    .last       (ent_last)
  );

  jscan_shifter #(.MAX_PAD(MAX_PAD), .MAX_TGT(MAX_TGT)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .shift_en  (shift_en),
    .pre_len   (pre_len),
    .tgt_len   (tgt_len),
    .post_len  (post_len),
    .pre_bits  (pre_bits),
    .tgt_bits  (tgt_bits),
    .post_bits (post_bits),
    .pre_ones  (pre_ones),
    .post_ones (post_ones),
    .cap_en    (cap_en),
    .tdo       (tdo),
    .tdi       (shf_tdi),
    .last      (shf_last),
    .zero_len  (zero_len),
    .cap_data  (cap_data)
  );

endmodule

// File: tb/tb_jscan_engine.sv
module tb_jscan_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        scan_ir = 1'b0;
  logic [3:0]  cur_state = 4'd0;
  logic [3:0]  stop_state = 4'd0;
  logic [4:0]  pre_len = '0;
  logic [5:0]  tgt_len = '0;
  logic [4:0]  post_len = '0;
  logic [15:0] pre_bits = '0;
  logic [31:0] tgt_bits = '0;
  logic [15:0] post_bits = '0;
  logic        pre_ones = 1'b0;
  logic        post_ones = 1'b0;
  logic        cap_en = 1'b0;
  logic        tdo;
  logic        nav_done = 1'b0;
  logic        tms, tdi, bit_vld, nav_req, busy, done;
  logic [3:0]  nav_state;
  logic [31:0] cap_data;

  always #2.5 clk = ~clk;

  jscan_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .scan_ir(scan_ir),
    .cur_state(cur_state), .stop_state(stop_state),
    .pre_len(pre_len), .tgt_len(tgt_len), .post_len(post_len),
    .pre_bits(pre_bits), .tgt_bits(tgt_bits), .post_bits(post_bits),
    .pre_ones(pre_ones), .post_ones(post_ones), .cap_en(cap_en),
    .tdo(tdo), .nav_done(nav_done), .tms(tms), .tdi(tdi),
    .bit_vld(bit_vld), .nav_req(nav_req), .nav_state(nav_state),
    .busy(busy), .done(done), .cap_data(cap_data)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench TAP model (R1 codes)
  logic [3:0]  tap = 4'd0;
  logic [6:0]  sh_cnt = '0;
  logic [63:0] tdo_pat = '0;
  logic        overlap = 1'b0;

  function automatic logic [3:0] tap_next(input logic [3:0] s, input logic m);
    case (s)
      4'd0:  return m ? 4'd2  : 4'd0;
      4'd1:  return m ? 4'd1  : 4'd0;
      4'd2:  return m ? 4'd9  : 4'd3;
      4'd3:  return m ? 4'd5  : 4'd4;
      4'd4:  return m ? 4'd5  : 4'd4;
      4'd5:  return m ? 4'd8  : 4'd6;
      4'd6:  return m ? 4'd7  : 4'd6;
      4'd7:  return m ? 4'd8  : 4'd4;
      4'd8:  return m ? 4'd2  : 4'd0;
      4'd9:  return m ? 4'd1  : 4'd10;
      4'd10: return m ? 4'd12 : 4'd11;
      4'd11: return m ? 4'd12 : 4'd11;
      4'd12: return m ? 4'd15 : 4'd13;
      4'd13: return m ? 4'd14 : 4'd13;
      4'd14: return m ? 4'd15 : 4'd11;
      default: return m ? 4'd2 : 4'd0;
    endcase
  endfunction

  assign tdo = ((tap == 4'd4) || (tap == 4'd11)) ? tdo_pat[sh_cnt[5:0]] : 1'b0;

  always @(posedge clk) begin
    if (bit_vld) begin
      tap <= tap_next(tap, tms);
      if ((tap == 4'd4) || (tap == 4'd11)) sh_cnt <= sh_cnt + 7'd1;
    end else if (nav_done) begin
      tap <= nav_state;
    end
  end

  // scoreboard queues
  logic [1:0] exp_q[$];
  logic [3:0] nav_q[$];

  // monitor: compare every TCK step against the queue (R3/R4/R6/R7/R8, R12)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && bit_vld) begin
        if (nav_req) overlap = 1'b1;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R12 unexpected TCK step", {62'd0, tms, tdi}, 64'd0);
        end else begin
          logic [1:0] e;
          e = exp_q.pop_front();
          chk({tms, tdi} == e, "R3/R4/R6/R7/R8 tms,tdi step", {62'd0, tms, tdi}, {62'd0, e});
        end
      end
    end
  end

  // navigator model: acknowledges after three cycles (R5, R9)
  initial begin
    int wait_n;
    wait_n = 0;
    forever begin
      @(negedge clk);
      if (nav_done) begin
        nav_done = 1'b0;
      end else if (rst_n && nav_req) begin
        wait_n++;
        if (wait_n == 3) begin
          wait_n = 0;
          if (nav_q.size() == 0) begin
            chk(1'b0, "R5/R9 unexpected navigation", {60'd0, nav_state}, 64'd0);
          end else begin
            logic [3:0] e;
            e = nav_q.pop_front();
            chk(nav_state == e, "R5/R9 navigation target", {60'd0, nav_state}, {60'd0, e});
          end
          nav_done = 1'b1;
        end
      end
    end
  end

  logic [31:0] exp_cap = '0;

  task automatic run_scan(input logic ir, input logic [3:0] cur, input logic [3:0] stop,
                          input int pl, input int tl, input int ql,
                          input logic [15:0] pb, input logic [31:0] tb, input logic [15:0] qb,
                          input logic pone, input logic qone, input logic cen,
                          input logic [63:0] pat, input logic poke);
    int total;
    int n;
    logic [3:0] pause_c;
    logic stable;
    total   = pl + tl + ql;
    pause_c = ir ? 4'd13 : 4'd6;
    stable  = (cur == 4'd0) || (cur == 4'd6) || (cur == 4'd13);
    // driver: expected stream
    if (!stable) nav_q.push_back(4'd0);
    if (stable && cur != 4'd0) begin
      exp_q.push_back(2'b10); exp_q.push_back(2'b10);
    end
    exp_q.push_back(2'b10);
    if (ir) exp_q.push_back(2'b10);
    exp_q.push_back(2'b00);
    exp_q.push_back(total == 0 ? 2'b10 : 2'b00);
    for (int i = 0; i < total; i++) begin
      logic b;
      if (i < pl)           b = pone ? 1'b1 : pb[i];
      else if (i < pl + tl) b = tb[i - pl];
      else                  b = qone ? 1'b1 : qb[i - pl - tl];
      exp_q.push_back({(i == total - 1), b});
    end
    exp_q.push_back(2'b00);
    if (stop != pause_c) nav_q.push_back(stop);
    if (cen) begin
      exp_cap = '0;
      for (int k = 0; k < tl; k++) exp_cap[k] = pat[pl + k];
    end
    // apply
    @(negedge clk);
    tap = cur; sh_cnt = '0; tdo_pat = pat; overlap = 1'b0;
    scan_ir = ir; cur_state = cur; stop_state = stop;
    pre_len = 5'(pl); tgt_len = 6'(tl); post_len = 5'(ql);
    pre_bits = pb; tgt_bits = tb; post_bits = qb;
    pre_ones = pone; post_ones = qone; cap_en = cen;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk);
      chk(busy == 1'b1, "R2 busy during scan", {63'd0, busy}, 64'd1);
      start = 1'b1; scan_ir = ~ir; tgt_len = 6'd5; cap_en = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 600) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R2 done reached", {63'd0, done}, 64'd1);
    chk(exp_q.size() == 0, "R2/R6 stream fully consumed", 64'(exp_q.size()), 64'd0);
    chk(nav_q.size() == 0, "R5/R9 navigation requests issued", 64'(nav_q.size()), 64'd0);
    chk(cap_data == exp_cap, cen ? "R10 captured target" : "R11 capture unchanged",
        {32'd0, cap_data}, {32'd0, exp_cap});
    @(negedge clk);
    chk(tap == stop, "R8/R9 final TAP state", {60'd0, tap}, {60'd0, stop});
    chk(!done && !busy, "R2 done single pulse", {62'd0, done, busy}, 64'd0);
    chk(!overlap, "R12 nav_req with bit_vld", {63'd0, overlap}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !bit_vld && !nav_req, "R2 reset idle outputs",
        {60'd0, busy, done, bit_vld, nav_req}, 64'd0);
    chk(cap_data == '0, "R10 reset capture", {32'd0, cap_data}, 64'd0);

    // R3 data scan from idle, ones preamble, stop in pause
    run_scan(1'b0, 4'd0, 4'd6, 3, 8, 2, 16'h0000, 32'h0000_00B4, 16'h0001,
             1'b1, 1'b0, 1'b1, 64'h0000_0000_0000_5A96, 1'b0);
    // R4 instruction scan from DR pause, ones postamble, stop idle
    run_scan(1'b1, 4'd6, 4'd0, 5, 6, 4, 16'h0016, 32'h0000_0029, 16'h0000,
             1'b0, 1'b1, 1'b1, 64'h0000_0000_0000_C3A5, 1'b0);
    // R4 instruction scan from IR pause, no padding, last bit is a target bit
    run_scan(1'b1, 4'd13, 4'd13, 0, 10, 0, 16'h0000, 32'h0000_02D3, 16'h0000,
             1'b0, 1'b0, 1'b1, 64'h0000_0000_0000_0357, 1'b0);
    // R5 start from DR shift, stop in test-logic-reset
    run_scan(1'b0, 4'd4, 4'd1, 1, 4, 1, 16'h0001, 32'h0000_0006, 16'h0000,
             1'b0, 1'b0, 1'b1, 64'h0000_0000_0000_002B, 1'b0);
    // R11 capture disabled, with a start poke while busy (R2)
    run_scan(1'b0, 4'd0, 4'd6, 2, 12, 3, 16'h0002, 32'h0000_0A5C, 16'h0005,
             1'b0, 1'b0, 1'b0, 64'h0000_0000_000F_FFFF, 1'b1);
    // R8 zero-length scan from DR pause
    run_scan(1'b0, 4'd6, 4'd6, 0, 0, 0, 16'h0000, 32'h0000_0000, 16'h0000,
             1'b0, 1'b0, 1'b1, 64'h0, 1'b0);
    // R6 R7 R10 full-length instruction scan
    run_scan(1'b1, 4'd0, 4'd13, 16, 32, 16, 16'hB3C1, 32'hDEAD_1F27, 16'h7E11,
             1'b0, 1'b0, 1'b1, 64'h9C3E_51A7_0F6D_28B4, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule